// File: doc/BRIEF.md
# Mantissa and Exponent Float Packer

This block turns an internal floating-point value into an IEEE-754 single-precision word. The value is given as a 32-bit mantissa with an explicit leading one in bit 31 and a signed 32-bit unbiased exponent. A sticky/carry bit from the operation that produced the mantissa takes part in rounding. The sign is taken from bit 31 of a separate operand word.

The conversion logic is combinational and selects one of five outcomes in a fixed order: pass a NaN or infinity through, saturate to infinity, flush to zero, zero for an empty mantissa, or the normal packed value. The normal path adds a +128 bias to the exponent and rounds to nearest even. The rounding increment is added to the joined exponent and fraction field, so a fraction that overflows carries into the exponent. The packed word is held in an output register, so it appears one clock after the inputs are applied.

Top module: `fpk_packer`

## Requirements
- R1: The round increment is 1 exactly when mantissa bit 7 is set and at least one of mantissa bit 8, any of mantissa bits 6:0, or the sticky input is set. Otherwise it is 0.
- R2: When mantissa bit 31 is clear and the exponent equals 255, the result exponent field (bits 30:23) is 255 and the fraction field (bits 22:0) is mantissa bits 30:8, with no rounding applied.
- R3: When R2 does not apply, mantissa bit 31 is set and the exponent is 127 or more (signed), bits 30:0 of the result are exponent 255 and fraction 0.
- R4: When R2 and R3 do not apply, mantissa bit 31 is set and the exponent is -128 or less (signed), bits 30:0 of the result are zero.
- R5: When R2 to R4 do not apply and the mantissa is all zero, bits 30:0 of the result are zero, whatever the sticky input is.
- R6: In the normal case the biased exponent is the low 8 bits of exponent+128 if mantissa bit 31 is set, and 0 if it is clear. It is joined above mantissa bits 30:8 to form a 31-bit field.
- R7: The round increment is added to that 31-bit field, so a fraction of all ones that rounds up clears the fraction and increments the exponent field.
- R8: Result bit 31 always equals bit 31 of the sign operand.
- R9: The result is registered. It reflects the inputs present at the previous rising clock edge, and a synchronous active-high reset clears it to 0.
- R10: The special cases are tested in the order R2, R3, R4, R5. An all-zero mantissa with exponent 255 therefore gives exponent 255 and fraction 0, and a set bit 31 with exponent 255 gives infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mant_i | input | 32 | Mantissa, leading one in bit 31 |
| exp_i | input | 32 | Signed unbiased exponent |
| sticky_i | input | 1 | Sticky/carry bit from the prior operation |
| sign_src_i | input | 32 | Operand whose bit 31 gives the sign |
| word_o | output | 32 | Registered single-precision result |

## Verification
The bench targets the round-to-nearest-even tie. A tie with an even bit 8 must stay put unless the sticky bit is set. A design that ignores the sticky bit or rounds ties upward returns a fraction that is one too large or one too small. The boundary exponents 126, 127, -127 and -128, plus the most negative exponent, expose unsigned comparisons or off-by-one limits: they wrongly give infinity, zero or a wrapped exponent. Vectors with a fraction of all ones that rounds up, and with overlapping special conditions such as an empty mantissa at exponent 255, catch a dropped carry into the exponent and a wrong check order.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  // Outcome chosen by the classifier, listed by priority.
  typedef enum logic [2:0] {
    CLS_PASS  = 3'd0,
    CLS_INF   = 3'd1,
    CLS_UNDER = 3'd2,
    CLS_ZERO  = 3'd3,
    CLS_NORM  = 3'd4
  } pk_class_e;

endpackage

// File: rtl/fpk_round.sv
module fpk_round #(
  parameter int MANT_W = 32,
  parameter int FW     = 23
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  output logic              rnd_o
);
  // Lowest mantissa bit kept in the fraction, and the bit just below it.
  localparam int KEEP_LSB = MANT_W - 1 - FW;
  localparam int HALF_BIT = KEEP_LSB - 1;

  logic below_half;

  always_comb begin
    below_half = |mant_i[HALF_BIT-1:0];
    rnd_o      = mant_i[HALF_BIT] & (mant_i[KEEP_LSB] | below_half | sticky_i);
  end

endmodule

// File: rtl/fpk_classify.sv
module fpk_classify
  import fpk_pkg::*;
#(
  parameter int MANT_W      = 32,
  parameter int EXP_W       = 32,
  parameter int SPECIAL_EXP = 255,
  parameter int OVF_LIM     = 127,
  parameter int UNF_LIM     = -128
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output pk_class_e         cls_o
);
  localparam logic signed [EXP_W-1:0] SPECIAL_S = EXP_W'(SPECIAL_EXP);
  localparam logic signed [EXP_W-1:0] OVF_S     = EXP_W'(OVF_LIM);
  localparam logic signed [EXP_W-1:0] UNF_S     = EXP_W'(UNF_LIM);

  logic                    lead;
  logic signed [EXP_W-1:0] exp_s;

  always_comb begin
    lead  = mant_i[MANT_W-1];
    exp_s = $signed(exp_i);
    if (!lead && (exp_s == SPECIAL_S))
      cls_o = CLS_PASS;
    else if (lead && (exp_s >= OVF_S))
      cls_o = CLS_INF;
    else if (lead && (exp_s <= UNF_S))
      cls_o = CLS_UNDER;
    else if (mant_i == '0)
      cls_o = CLS_ZERO;
    else
      cls_o = CLS_NORM;
  end

endmodule

// File: rtl/fpk_assemble.sv
module fpk_assemble
  import fpk_pkg::*;
#(
  parameter int MANT_W = 32,
  parameter int EW     = 8,
  parameter int FW     = 23,
  parameter int BIAS   = 128
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EW-1:0]     exp_lo_i,
  input  logic              rnd_i,
  input  logic              sign_i,
  input  pk_class_e         cls_i,
  output logic [EW+FW:0]    word_o
);
  localparam int FIELD_W = EW + FW;

  logic [EW-1:0]      biased;
  logic [FW-1:0]      frac_raw;
  logic [FIELD_W-1:0] joined;
  logic [FIELD_W-1:0] body;

  always_comb begin
    frac_raw = mant_i[MANT_W-2 -: FW];
    biased   = mant_i[MANT_W-1] ? (exp_lo_i + EW'(BIAS)) : '0;
    joined   = {biased, frac_raw} + FIELD_W'(rnd_i);
    unique case (cls_i)
      CLS_PASS:  body = {{EW{1'b1}}, frac_raw};
      CLS_INF:   body = {{EW{1'b1}}, {FW{1'b0}}};
      CLS_UNDER: body = '0;
      CLS_ZERO:  body = '0;
      default:   body = joined;
    endcase
    word_o = {sign_i, body};
  end

endmodule

// File: rtl/fpk_packer.sv
module fpk_packer
  import fpk_pkg::*;
#(
  parameter int MANT_W      = 32,
  parameter int EXP_W       = 32,
  parameter int EW          = 8,
  parameter int FW          = 23,
  parameter int BIAS        = 128,
  parameter int SPECIAL_EXP = 255,
  parameter int OVF_LIM     = 127,
  parameter int UNF_LIM     = -128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sticky_i,
  input  logic [MANT_W-1:0] sign_src_i,
  output logic [EW+FW:0]    word_o
);
  localparam int OUT_W    = EW + FW + 1;
  localparam int KEEP_LSB = MANT_W - 1 - FW;

  pk_class_e         cls;
  logic              rnd;
  logic [OUT_W-1:0]  word_d;
  logic [OUT_W-1:0]  word_q;
  logic              unused_sign_bits;

  assign unused_sign_bits = ^sign_src_i[MANT_W-2:0];

  fpk_round #(.MANT_W(MANT_W), .FW(FW)) u_round (
    .mant_i   (mant_i),
    .sticky_i (sticky_i),
    .rnd_o    (rnd)
  );

  fpk_classify #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .SPECIAL_EXP(SPECIAL_EXP),
    .OVF_LIM(OVF_LIM), .UNF_LIM(UNF_LIM)
  ) u_classify (
    .mant_i (mant_i),
    .exp_i  (exp_i),
    .cls_o  (cls)
  );

  fpk_assemble #(.MANT_W(MANT_W), .EW(EW), .FW(FW), .BIAS(BIAS)) u_assemble (
    .mant_i   (mant_i),
    .exp_lo_i (exp_i[EW-1:0]),
    .rnd_i    (rnd),
    .sign_i   (sign_src_i[MANT_W-1]),
    .cls_i    (cls),
    .word_o   (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d;
  end

  assign word_o = word_q;

  // Checks on the registered result against the inputs one edge earlier.
  logic signed [EXP_W-1:0] exp_s;
  assign exp_s = $signed(exp_i);

  // R8
  a_r8_sign_copy: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> word_o[OUT_W-1] == $past(sign_src_i[MANT_W-1]));

  // R2 and R10
  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    (!mant_i[MANT_W-1] && exp_s == EXP_W'(SPECIAL_EXP))
    |=> word_o[OUT_W-2:0] == {{EW{1'b1}}, $past(mant_i[MANT_W-2 -: FW])});

  // R3
  a_r3_saturate_inf: assert property (@(posedge clk) disable iff (rst)
    (mant_i[MANT_W-1] && exp_s >= EXP_W'(OVF_LIM))
    |=> word_o[OUT_W-2:0] == {{EW{1'b1}}, {FW{1'b0}}});

  // R4
  a_r4_flush_zero: assert property (@(posedge clk) disable iff (rst)
    (mant_i[MANT_W-1] && exp_s <= EXP_W'(UNF_LIM))
    |=> word_o[OUT_W-2:0] == '0);

  // R5
  a_r5_empty_mantissa: assert property (@(posedge clk) disable iff (rst)
    (mant_i == '0 && exp_s != EXP_W'(SPECIAL_EXP))
    |=> word_o[OUT_W-2:0] == '0);

  // R1: with the half bit clear, a normal result keeps the fraction unchanged.
  a_r1_no_round_below_half: assert property (@(posedge clk) disable iff (rst)
    (mant_i[MANT_W-1] && exp_s < EXP_W'(OVF_LIM) && exp_s > EXP_W'(UNF_LIM)
     && !mant_i[KEEP_LSB-1])
    |=> word_o[FW-1:0] == $past(mant_i[MANT_W-2 -: FW]));

endmodule

// File: tb/fpk_packer_tb.sv
module fpk_packer_tb;

  logic        clk;
  logic        rst;
  logic [31:0] mant;
  logic [31:0] expo;
  logic        sticky;
  logic [31:0] sgn;
  logic [31:0] word;

  int checks;
  int errors;

  fpk_packer u_dut (
    .clk        (clk),
    .rst        (rst),
    .mant_i     (mant),
    .exp_i      (expo),
    .sticky_i   (sticky),
    .sign_src_i (sgn),
    .word_o     (word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {mantissa, exponent, sticky, sign word, expected result}
  localparam int NV = 22;
  localparam logic [128:0] VEC [NV] = '{
    {32'h8000_0000, 32'd0,         1'b0, 32'h0000_0000, 32'h4000_0000}, // R6 plain
    {32'hC000_0000, 32'd0,         1'b0, 32'h8000_0000, 32'hC040_0000}, // R6 R8
    {32'h8000_0180, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 32'h3F80_0002}, // R1 odd tie up
    {32'h8000_0080, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 32'h3F80_0000}, // R1 even tie stays
    {32'h8000_0080, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 32'h3F80_0001}, // R1 sticky breaks tie
    {32'h8000_0081, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 32'h3F80_0001}, // R1 above half
    {32'h8000_007F, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 32'h3F80_0000}, // R1 below half
    {32'hFFFF_FF80, 32'd0,         1'b0, 32'h0000_0000, 32'h4080_0000}, // R7 carry to exponent
    {32'h7FC0_0000, 32'd255,       1'b1, 32'h0000_0000, 32'h7FFF_C000}, // R2 pass NaN
    {32'h0000_0000, 32'd255,       1'b0, 32'h8000_0000, 32'hFF80_0000}, // R10 empty at 255
    {32'h8000_0000, 32'd127,       1'b0, 32'h0000_0000, 32'h7F80_0000}, // R3 limit
    {32'h8000_0000, 32'd126,       1'b0, 32'h0000_0000, 32'h7F00_0000}, // R6 top normal
    {32'h8000_0000, 32'hFFFF_FF80, 1'b0, 32'h8000_0000, 32'h8000_0000}, // R4 limit -128
    {32'h8000_0000, 32'hFFFF_FF81, 1'b0, 32'h0000_0000, 32'h0080_0000}, // R6 -127
    {32'h0000_0000, 32'd5,         1'b1, 32'h8000_0000, 32'h8000_0000}, // R5 zero
    {32'h0000_0100, 32'd3,         1'b0, 32'h0000_0000, 32'h0000_0001}, // R6 lead clear
    {32'h7FFF_FF80, 32'd0,         1'b0, 32'h0000_0000, 32'h0080_0000}, // R7 lead clear carry
    {32'h8123_4500, 32'd255,       1'b0, 32'h0000_0000, 32'h7F80_0000}, // R10 lead set at 255
    {32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'h8000_0000, 32'hFF80_0000}, // R3 huge
    {32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R4 most negative
    {32'h4000_0000, 32'd200,       1'b0, 32'h0000_0000, 32'h0040_0000}, // R6 lead clear exp ignored
    {32'hFFFF_FFFF, 32'd126,       1'b0, 32'h0000_0000, 32'h7F80_0000}  // R7 rounds into 255
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp_v,
                       input string tag);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp_v);
    end
  endtask

  task automatic apply(input logic [31:0] m, input logic [31:0] e,
                       input logic c, input logic [31:0] s);
    @(negedge clk);
    mant = m; expo = e; sticky = c; sgn = s;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst    = 1'b1;
    mant   = 32'hFFFF_FFFF;
    expo   = 32'd3;
    sticky = 1'b1;
    sgn    = 32'h8000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(word, 32'h0000_0000, "R9 reset clears output");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][128:97], VEC[i][96:65], VEC[i][64], VEC[i][63:32]);
      @(negedge clk);
      check(word, VEC[i][31:0], $sformatf("R1..R10 vector %0d", i));
    end

    // R9: output holds the old value until the next rising edge.
    apply(32'h8000_0000, 32'd0, 1'b0, 32'h0000_0000);
    @(negedge clk);
    apply(32'hC000_0000, 32'd0, 1'b0, 32'h8000_0000);
    #1;
    check(word, 32'h4000_0000, "R9 output waits for clock edge");
    @(negedge clk);
    check(word, 32'hC040_0000, "R9 output after one edge");

    // R8: only bit 31 of the sign operand matters.
    apply(32'h8000_0000, 32'd0, 1'b0, 32'h7FFF_FFFF);
    @(negedge clk);
    check(word, 32'h4000_0000, "R8 low sign bits ignored");

    // R5: sticky cannot make an empty mantissa nonzero.
    apply(32'h0000_0000, 32'hFFFF_FF00, 1'b1, 32'h0000_0000);
    @(negedge clk);
    check(word, 32'h0000_0000, "R5 empty mantissa with sticky");

    // R9: synchronous reset in mid run.
    @(negedge clk);
    rst = 1'b1;
    apply(32'h8000_0000, 32'd0, 1'b0, 32'h0000_0000);
    @(negedge clk);
    check(word, 32'h0000_0000, "R9 reset mid run");
    rst = 1'b0;
    @(negedge clk);
    check(word, 32'h4000_0000, "R9 resumes after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule